// File: doc/BRIEF.md
# Transmit Buffer Descriptor Walker

The walker serves one transmit channel. It follows a linked chain of buffer descriptors kept in a synchronous word memory, and turns the payload of each buffer into a byte stream for a downstream framer. Each descriptor has four 16-bit header words at consecutive addresses: a control/status word, a buffer-size word, a data-length word and a next-descriptor link. The payload follows the header, one byte per word in bits 7:0.

The walker reads the header and skips any buffer the CPU still owns. For a filled buffer it picks the byte count, streams the bytes over a valid/ready handshake and marks the frame's final byte. It then writes the control word back and moves to the linked descriptor. A link that cannot be valid puts the channel into a dead state. A gap in a frame is reported to the framer as an underrun. Control-word bits are: 15 empty, 14 command, 13 frame end, 12 bad link (status), 11 underrun (status).

The memory has one cycle of read latency. A read issued in one cycle returns its data in the next. A write completes in its own cycle.

Top module: `tx_desc_walker`

## Requirements
- R1: After reset, or in the cycle after `enable_i` is low, the walker issues no memory access and asserts neither `tx_valid_o`, `underrun_o` nor `dead_o`. When `enable_i` goes high, the walk starts at `start_addr_i`.
- R2: For a descriptor at base address B, the walker reads the header in the order B, B+1, B+2, B+3. It then reads payload byte k from address B+4+k and presents bits 7:0 of that word on `tx_data_o`.
- R3: If control bit 13 is 1, the byte count is bits 11:0 of word B+2, and `tx_last_o` is high only with the final byte. If bit 13 is 0, the count is bits 11:0 of word B+1, and `tx_last_o` stays low for the whole buffer.
- R4: While control bit 15 (empty) reads 1, the walker sends no bytes and reads the control word again. Consecutive reads are max(`poll_gap_i`,16)+2 cycles apart. Once bit 15 reads 0, the buffer is sent.
- R5: A buffer ends with exactly one memory write to address B, after the last byte has been accepted. That write sets bit 15 and keeps bits 14:13 and 10:0 as read. Bit 12 reports a bad link, and bit 11 reports an underrun on that descriptor.
- R6: A link equal to 0x0000 or in the range 0xFFF0 to 0xFFFF sets bits 12 and 11 in the write-back. After it, `dead_o` and `underrun_o` stay high and there is no further memory access until `enable_i` goes low.
- R7: If a frame is open (the previous buffer had bit 13 at 0) and the next control word reads empty, `underrun_o` rises. It stays high until bytes flow again. An empty descriptor at a frame boundary does not raise `underrun_o`.
- R8: A descriptor with bit 14 (command) set sends no bytes and is written back with bit 15 set. If it follows a partial buffer, `underrun_o` rises, bit 11 is set in its write-back, and the frame is closed.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o`, `tx_data_o` and `tx_last_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Channel enable; low aborts and idles the walker |
| start_addr_i | input | 16 | First descriptor address, taken when enabled |
| poll_gap_i | input | 8 | Re-poll spacing for an empty descriptor (minimum 16) |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Write qualifier for the access |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 16 | Write data (status write-back) |
| mem_rdata_i | input | 16 | Read data, one cycle after the read |
| tx_data_o | output | 8 | Byte to the framer |
| tx_valid_o | output | 1 | Byte valid |
| tx_last_o | output | 1 | Final byte of a frame |
| tx_ready_i | input | 1 | Framer accepts the byte |
| underrun_o | output | 1 | Data ran out inside a frame, or the link was bad |
| dead_o | output | 1 | Channel deactivated by a bad link |

## Verification
The hardest state to reach is an underrun in the middle of a frame that later heals. The bench gets there with a partial buffer whose link points at a descriptor still marked empty. It holds that state across several re-polls and measures the read spacing. Then it clears the empty bit in the memory model, as the CPU would, and checks that the stream resumes, the underrun drops and the status bit is written back. A command descriptor after a partial buffer is chained in a separate case. The bad-link cases use both forms of invalid link, and after each one the bench confirms that the memory stays quiet.

// File: rtl/tx_walk_pkg.sv
package tx_walk_pkg;
  localparam int BIT_EMPTY = 15;
  localparam int BIT_CMD   = 14;
  localparam int BIT_FE    = 13;
  localparam int BIT_INV   = 12;
  localparam int BIT_UND   = 11;
  localparam int HDR_WORDS = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_CAP_CTL, S_POLL, S_RD_W1, S_RD_W2, S_RD_W3,
    S_CAP_W3, S_RD_B, S_CAP_B, S_HOLD, S_WB, S_DEAD
  } walk_st_e;
endpackage

// File: rtl/tx_poll_timer.sv
module tx_poll_timer #(
  parameter int GAP_W   = 8,
  parameter int MIN_GAP = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             done_o
);
  localparam logic [GAP_W-1:0] MIN_V = GAP_W'(MIN_GAP);

  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] eff;

  assign eff    = (gap_i < MIN_V) ? MIN_V : gap_i;
  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= eff - GAP_W'(1);
    else if (!done_o) cnt_q <= cnt_q - GAP_W'(1);
  end
endmodule

// File: rtl/tx_link_check.sv
module tx_link_check #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] link_i,
  output logic          bad_o
);
  // zero, or all ones above the low nibble
  assign bad_o = (link_i == '0) || ((link_i | AW'(15)) == '1);
endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
  import tx_walk_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int CW      = 12,
  parameter int GAP_W   = 8,
  parameter int MIN_GAP = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [AW-1:0]    start_addr_i,
  input  logic [GAP_W-1:0] poll_gap_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  output logic             tx_last_o,
  input  logic             tx_ready_i,
  output logic             underrun_o,
  output logic             dead_o
);
  walk_st_e      st_q;
  logic [AW-1:0] base_q, next_q;
  logic [DW-1:0] ctl_q;
  logic [CW-1:0] size_q, len_q, cnt_q, idx_q, cnt_sel;
  logic [7:0]    data_q;
  logic          und_q, desc_und_q, mid_q;
  logic          poll_done, link_bad, last_byte, poll_load;

  assign cnt_sel   = ctl_q[BIT_FE] ? len_q : size_q;
  assign last_byte = (idx_q == cnt_q - CW'(1));
  assign poll_load = (st_q == S_CAP_CTL) && mem_rdata_i[BIT_EMPTY];

  tx_poll_timer #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(poll_load),
    .gap_i(poll_gap_i), .done_o(poll_done)
  );

  tx_link_check #(.AW(AW)) u_link (.link_i(next_q), .bad_o(link_bad));

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_q;
    mem_wdata_o = ctl_q;
    mem_wdata_o[BIT_EMPTY] = 1'b1;
    mem_wdata_o[BIT_INV]   = link_bad;
    mem_wdata_o[BIT_UND]   = desc_und_q | link_bad;
    case (st_q)
      S_RD_CTL: mem_req_o = 1'b1;
      S_RD_W1: begin mem_req_o = 1'b1; mem_addr_o = base_q + AW'(1); end
      S_RD_W2: begin mem_req_o = 1'b1; mem_addr_o = base_q + AW'(2); end
      S_RD_W3: begin mem_req_o = 1'b1; mem_addr_o = base_q + AW'(3); end
      S_RD_B: begin
        mem_req_o  = 1'b1;
        mem_addr_o = base_q + AW'(HDR_WORDS) + AW'(idx_q);
      end
      S_WB: begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      default: ;
    endcase
  end

  assign tx_data_o  = data_q;
  assign tx_valid_o = (st_q == S_HOLD);
  assign tx_last_o  = tx_valid_o && ctl_q[BIT_FE] && last_byte;
  assign underrun_o = und_q;
  assign dead_o     = (st_q == S_DEAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      base_q <= '0; next_q <= '0; ctl_q <= '0;
      size_q <= '0; len_q <= '0; cnt_q <= '0; idx_q <= '0;
      data_q <= '0; und_q <= 1'b0; desc_und_q <= 1'b0; mid_q <= 1'b0;
    end else if (!enable_i) begin
      st_q <= S_IDLE;
      und_q <= 1'b0; desc_und_q <= 1'b0; mid_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          base_q <= start_addr_i;
          st_q   <= S_RD_CTL;
        end
        S_RD_CTL: st_q <= S_CAP_CTL;
        S_CAP_CTL: begin
          ctl_q <= mem_rdata_i;
          if (mem_rdata_i[BIT_EMPTY]) begin
            if (mid_q) begin und_q <= 1'b1; desc_und_q <= 1'b1; end
            st_q <= S_POLL;
          end else begin
            if (mem_rdata_i[BIT_CMD] && mid_q) begin
              und_q <= 1'b1; desc_und_q <= 1'b1; mid_q <= 1'b0;
            end
            st_q <= S_RD_W1;
          end
        end
        S_POLL: if (poll_done) st_q <= S_RD_CTL;
        S_RD_W1: st_q <= S_RD_W2;
        S_RD_W2: begin size_q <= mem_rdata_i[CW-1:0]; st_q <= S_RD_W3; end
        S_RD_W3: begin len_q <= mem_rdata_i[CW-1:0]; st_q <= S_CAP_W3; end
        S_CAP_W3: begin
          next_q <= mem_rdata_i[AW-1:0];
          cnt_q  <= cnt_sel;
          idx_q  <= '0;
          st_q   <= (ctl_q[BIT_CMD] || cnt_sel == '0) ? S_WB : S_RD_B;
        end
        S_RD_B: st_q <= S_CAP_B;
        S_CAP_B: begin
          data_q <= mem_rdata_i[7:0];
          und_q  <= 1'b0;
          st_q   <= S_HOLD;
        end
        S_HOLD: if (tx_ready_i) begin
          if (last_byte) st_q <= S_WB;
          else begin idx_q <= idx_q + CW'(1); st_q <= S_RD_B; end
        end
        S_WB: begin
          desc_und_q <= 1'b0;
          mid_q <= !ctl_q[BIT_CMD] && !ctl_q[BIT_FE];
          if (link_bad) begin
            und_q <= 1'b1;
            st_q  <= S_DEAD;
          end else begin
            base_q <= next_q;
            st_q   <= S_RD_CTL;
          end
        end
        S_DEAD: st_q <= S_DEAD;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_desc_walker_chk.sv
module tx_desc_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [15:0] mem_wdata_o,
  input logic [7:0]  tx_data_o,
  input logic        tx_valid_o,
  input logic        tx_last_o,
  input logic        tx_ready_i,
  input logic        underrun_o,
  input logic        dead_o
);
  // R1
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !mem_req_o && !tx_valid_o && !dead_o);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !enable_i)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));
  // R3
  last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);
  // R5
  wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o && !tx_valid_o && mem_wdata_o[15]);
  // R5
  wb_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  // R6
  dead_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |-> !mem_req_o && !tx_valid_o && underrun_o);
endmodule

bind tx_desc_walker tx_desc_walker_chk u_chk (.*);

// File: tb/tx_desc_walker_test.sv
module tx_desc_walker_test;
  localparam int CLK_T = 10;

  logic        clk = 0, rst_n = 0, en = 0, rdy = 1;
  logic [15:0] start_a = 0;
  logic [7:0]  gap = 0;
  logic        req, we, tvalid, tlast, und, dead;
  logic [15:0] addr, wdata, rdata;
  logic [7:0]  tdata;

  logic [15:0] mem [0:4095];
  int n_chk = 0, n_err = 0, cyc = 0;
  int rx_n, rd_n, wr_n, viol, wt_prev, wt_int;
  logic [7:0]  rx_d [0:63];
  logic        rx_l [0:63];
  logic [15:0] rd_a [0:63];
  logic [15:0] wr_a [0:15];
  logic [15:0] wr_d [0:15];
  logic [15:0] watch;
  logic        rnd_mode = 0, pv = 0;
  logic [7:0]  pdat;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_T/2) clk = ~clk;

  tx_desc_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .start_addr_i(start_a),
    .poll_gap_i(gap), .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .tx_data_o(tdata),
    .tx_valid_o(tvalid), .tx_last_o(tlast), .tx_ready_i(rdy),
    .underrun_o(und), .dead_o(dead)
  );

  always @(posedge clk) begin
    if (req) begin
      if (we) mem[addr[11:0]] <= wdata;
      else    rdata <= mem[addr[11:0]];
    end
  end

  // monitor and ready driver, away from the active edge
  always @(negedge clk) begin
    logic nr;
    cyc = cyc + 1;
    if (pv && !rdy && (!tvalid || tdata !== pdat)) viol = viol + 1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    nr = rnd_mode ? lfsr[0] : 1'b1;
    rdy = nr;
    pv = tvalid; pdat = tdata;
    if (tvalid && nr) begin
      if (rx_n < 64) begin rx_d[rx_n] = tdata; rx_l[rx_n] = tlast; end
      rx_n = rx_n + 1;
    end
    if (req && !we) begin
      if (rd_n < 64) rd_a[rd_n] = addr;
      rd_n = rd_n + 1;
      if (addr == watch) begin wt_int = cyc - wt_prev; wt_prev = cyc; end
    end
    if (req && we) begin
      if (wr_n < 16) begin wr_a[wr_n] = addr; wr_d[wr_n] = wdata; end
      wr_n = wr_n + 1;
    end
    if (cyc > 150000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_logs();
    rx_n = 0; rd_n = 0; wr_n = 0; viol = 0; wt_prev = 0; wt_int = 0;
  endtask

  task automatic begin_case(input logic rm, input logic [7:0] g, input logic [15:0] w);
    en = 0;
    cycles(3);
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    rnd_mode = rm; gap = g; watch = w;
    clear_logs();
  endtask

  task automatic go(input logic [15:0] a);
    start_a = a; en = 1;
  endtask

  task automatic wait_wr(input int n, input string tag);
    int t = 0;
    while (wr_n < n && t < 20000) begin cycles(1); t++; end
    chk({tag, " write-back reached"}, wr_n >= n, 1);
  endtask

  task automatic desc(input int b, input logic [15:0] c, s, l, nx);
    mem[b] = c; mem[b+1] = s; mem[b+2] = l; mem[b+3] = nx;
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", tvalid, 0);
    chk("R1 req after reset", req, 0);
    chk("R1 underrun after reset", und, 0);
    chk("R1 dead after reset", dead, 0);
  endtask

  task automatic t_frame_and_poll();
    begin_case(0, 8'd5, 16'h0200);
    desc(12'h100, 16'h2000, 16'd9, 16'd3, 16'h0200);
    mem[12'h104] = 16'hAB11; mem[12'h105] = 16'hCD22; mem[12'h106] = 16'hEF33;
    mem[12'h200] = 16'h8000;
    go(16'h0100);
    wait_wr(1, "R5");
    cycles(80);
    chk("R3 byte count from length word", rx_n, 3);
    chk("R2 byte0", rx_d[0], 8'h11);
    chk("R2 byte1", rx_d[1], 8'h22);
    chk("R2 byte2", rx_d[2], 8'h33);
    chk("R3 last flags", {rx_l[0], rx_l[1], rx_l[2]}, 3'b001);
    for (int i = 0; i < 5; i++) chk("R2 read order", rd_a[i], 16'h0100 + i);
    chk("R5 one write", wr_n, 1);
    chk("R5 write addr", wr_a[0], 16'h0100);
    chk("R5 write data", wr_d[0], 16'hA000);
    chk("R4 poll spacing min clamp", wt_int, 18);
    chk("R7 empty at boundary no underrun", und, 0);
    chk("R4 no bytes while empty", rx_n, 3);
    desc(12'h200, 16'h2000, 16'd0, 16'd1, 16'h0240);
    mem[12'h204] = 16'h0044;
    mem[12'h240] = 16'h8000;
    wait_wr(2, "R4");
    cycles(4);
    chk("R4 sent after release", rx_n, 4);
    chk("R4 released byte", rx_d[3], 8'h44);
  endtask

  task automatic t_midframe_underrun();
    begin_case(1, 8'd40, 16'h0340);
    desc(12'h300, 16'h0000, 16'd2, 16'd7, 16'h0340);
    mem[12'h304] = 16'h00A1; mem[12'h305] = 16'h00A2;
    desc(12'h340, 16'hA000, 16'd5, 16'd1, 16'h0380);
    mem[12'h344] = 16'h00B1;
    mem[12'h380] = 16'h8000;
    go(16'h0300);
    wait_wr(1, "R3");
    cycles(120);
    chk("R3 partial uses size word", rx_n, 2);
    chk("R3 no last on partial", {rx_l[0], rx_l[1]}, 2'b00);
    chk("R9 bytes under stall", {rx_d[0], rx_d[1]}, 16'hA1A2);
    chk("R5 partial write-back", wr_d[0], 16'h8000);
    chk("R7 underrun mid-frame", und, 1);
    chk("R4 poll spacing 40", wt_int, 42);
    mem[12'h340] = 16'h2000;
    wait_wr(2, "R7");
    cycles(60);
    chk("R7 resumed byte", rx_d[2], 8'hB1);
    chk("R3 last on resumed", rx_l[2], 1);
    chk("R7 underrun status written", wr_d[1], 16'hA800);
    chk("R7 underrun cleared", und, 0);
    chk("R9 held while stalled", viol, 0);
  endtask

  task automatic t_command();
    begin_case(0, 8'd0, 16'hFFFF);
    desc(12'h400, 16'h4000, 16'd3, 16'd3, 16'h0440);
    mem[12'h404] = 16'h00EE;
    desc(12'h440, 16'h2000, 16'd9, 16'd1, 16'h0480);
    mem[12'h444] = 16'h0055;
    desc(12'h480, 16'h0000, 16'd1, 16'd9, 16'h04C0);
    mem[12'h484] = 16'h0066;
    desc(12'h4C0, 16'h4000, 16'd2, 16'd2, 16'h0500);
    mem[12'h500] = 16'h8000;
    go(16'h0400);
    wait_wr(4, "R8");
    cycles(40);
    chk("R8 command sends nothing", rx_n, 2);
    chk("R8 bytes", {rx_d[0], rx_d[1]}, 16'h5566);
    chk("R8 command write-back", wr_d[0], 16'hC000);
    chk("R5 data write-back", wr_d[1], 16'hA000);
    chk("R8 mid-frame command status", wr_d[3], 16'hC800);
    chk("R8 mid-frame command underrun", und, 1);
    chk("R5 write count", wr_n, 4);
  endtask

  task automatic t_bad_link();
    int snap;
    begin_case(0, 8'd0, 16'hFFFF);
    desc(12'h600, 16'h2000, 16'd0, 16'd1, 16'hFFF3);
    mem[12'h604] = 16'h0077;
    go(16'h0600);
    wait_wr(1, "R6");
    cycles(10);
    chk("R6 FFFx status", wr_d[0], 16'hB800);
    chk("R6 dead", dead, 1);
    chk("R6 underrun", und, 1);
    snap = rd_n;
    cycles(50);
    chk("R6 memory quiet", rd_n, snap);
    en = 0;
    cycles(2);
    chk("R1 dead cleared by disable", dead, 0);
    chk("R1 underrun cleared by disable", und, 0);
    desc(12'h700, 16'h2000, 16'd0, 16'd1, 16'h0000);
    mem[12'h704] = 16'h0088;
    clear_logs();
    go(16'h0700);
    wait_wr(1, "R6");
    cycles(10);
    chk("R6 restart byte", rx_d[0], 8'h88);
    chk("R6 zero link status", wr_d[0], 16'hB800);
    chk("R6 dead on zero link", dead, 1);
  endtask

  initial begin
    watch = 16'hFFFF;
    clear_logs();
    cycles(3);
    t_reset();
    rst_n = 1;
    cycles(2);
    t_reset();
    t_frame_and_poll();
    t_midframe_underrun();
    t_command();
    t_bad_link();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule